// File: doc/BRIEF.md
# Serially Configured Five-Lane Programmable Delay

This block adds a programmable delay of zero to seven clock stages to each of five input streams that feed a mixing datapath. The five streams are the first data word, the second data word, the mix coefficient together with its load enable, the number-format flag and the rounding select. Each stream has its own seven-stage delay line, clocked every cycle, and a tap selector that picks the live input or any of the seven stages.

The tap selects sit in a 15-bit configuration word made of five 3-bit fields. The word is written one bit at a time through a serial data pin and a load strobe. Both pins are sampled in the block's single clock, and each rising edge of the sampled strobe shifts in one bit. A static bypass input holds the word at zero so that every stream passes straight through. The reset is asynchronous active-low and is released synchronously inside the block.

Top module: `prog_delay_bank`

## Requirements
- R1: After reset every field of the configuration word is zero, so each output equals its input in the same cycle.
- R2: The fields map to the streams as follows: bits 2:0 to the first data word, bits 5:3 to the second data word, bits 8:6 to the coefficient and its load enable, bits 11:9 to the format flag, and bits 14:12 to the rounding select.
- R3: A field holding the value d (0 to 7) makes that stream's output equal to its input from d clock cycles earlier. The value 0 passes the input through without any register.
- R4: Each detected rising strobe edge shifts the word one place toward bit 0 and writes the serial bit, sampled with that strobe edge, into bit 14. After fifteen edges the first bit sent sits at bit 0.
- R5: A strobe that stays high, stays low or falls causes no shift. There is exactly one shift per rising edge, however long the strobe is held high.
- R6: While bypass is high the word is zero and strobe edges are ignored. After bypass falls the word stays zero until it is loaded again.
- R7: The coefficient load enable is delayed by exactly the same number of stages as the coefficient.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Single clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| bypass | input | 1 | Static; high forces all delays to zero |
| cfg_strobe | input | 1 | Serial load strobe, one shift per rising edge |
| cfg_bit | input | 1 | Serial configuration bit |
| a_in | input | DATA_W | First data stream |
| b_in | input | DATA_W | Second data stream |
| coef_in | input | COEF_W | Mix coefficient stream |
| coef_ld | input | 1 | Coefficient load enable |
| fmt_in | input | 1 | Number-format flag |
| rsel_in | input | RSEL_W | Rounding select |
| a_out | output | DATA_W | Delayed first data |
| b_out | output | DATA_W | Delayed second data |
| coef_out | output | COEF_W | Delayed coefficient |
| coef_ld_out | output | 1 | Delayed load enable |
| fmt_out | output | 1 | Delayed format flag |
| rsel_out | output | RSEL_W | Delayed rounding select |

## Verification
The configuration word cannot be read directly. A wrong bit in it therefore shows up as a stream whose output lags its input history by the wrong number of cycles, and this is visible on the first cycle checked after the load completes. A double shift or a shift in the wrong direction moves every field at once, so several lanes disagree with their expected delays together. A coefficient enable that is out of step with the coefficient shows up as a mismatch on the enable output on the first cycle where the two input histories differ.

// File: rtl/pdb_pkg.sv
package pdb_pkg;
  localparam int NUM_LANES = 5;

  typedef enum int {
    LN_A    = 0,
    LN_B    = 1,
    LN_COEF = 2,
    LN_FMT  = 3,
    LN_RSEL = 4
  } lane_e;
endpackage

// File: rtl/pdb_rst_sync.sv
module pdb_rst_sync (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) sync_q <= '0;
    else         sync_q <= {sync_q[0], 1'b1};
  end

  assign srst_n = sync_q[1];
endmodule

// File: rtl/pdb_cfg_shreg.sv
module pdb_cfg_shreg #(
  parameter int CFG_W = 15
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bypass,
  input  logic             strobe,
  input  logic             sdata,
  output logic [CFG_W-1:0] cfg
);
  logic             str_q, str_prev_q, bit_q;
  logic             rise;
  logic             cfg_en;
  logic [CFG_W-1:0] cfg_q, cfg_d;

  // edge between the current sample and the one before it
  assign rise   = str_q & ~str_prev_q;
  assign cfg_en = bypass | rise;

  always_comb begin
    cfg_d = cfg_q;
    if (bypass)    cfg_d = '0;
    else if (rise) cfg_d = {bit_q, cfg_q[CFG_W-1:1]};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      str_q      <= 1'b0;
      str_prev_q <= 1'b0;
      bit_q      <= 1'b0;
    end else begin
      str_q      <= strobe;
      str_prev_q <= str_q;
      bit_q      <= sdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cfg_q <= '0;
    else if (cfg_en) cfg_q <= cfg_d;
  end

  assign cfg = cfg_q;
endmodule

// File: rtl/pdb_delay_lane.sv
module pdb_delay_lane #(
  parameter int W     = 8,
  parameter int SEL_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [SEL_W-1:0] sel,
  input  logic [W-1:0]     din,
  output logic [W-1:0]     dout
);
  localparam int DEPTH = (1 << SEL_W) - 1;
  localparam int NTAPS = DEPTH + 1;

  logic [W-1:0] stg_q [DEPTH];
  logic [W-1:0] stg_d [DEPTH];
  logic [W-1:0] taps  [NTAPS];

  always_comb begin
    stg_d[0] = din;
    for (int k = 1; k < DEPTH; k++) stg_d[k] = stg_q[k-1];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int k = 0; k < DEPTH; k++) stg_q[k] <= '0;
    end else begin
      for (int k = 0; k < DEPTH; k++) stg_q[k] <= stg_d[k];
    end
  end

  assign taps[0] = din;
  for (genvar k = 1; k < NTAPS; k++) begin : g_tap
    assign taps[k] = stg_q[k-1];
  end

  assign dout = taps[sel];
endmodule

// File: rtl/prog_delay_bank.sv
module prog_delay_bank #(
  parameter int DATA_W  = 12,
  parameter int COEF_W  = 12,
  parameter int RSEL_W  = 2,
  parameter int FIELD_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bypass,
  input  logic              cfg_strobe,
  input  logic              cfg_bit,
  input  logic [DATA_W-1:0] a_in,
  input  logic [DATA_W-1:0] b_in,
  input  logic [COEF_W-1:0] coef_in,
  input  logic              coef_ld,
  input  logic              fmt_in,
  input  logic [RSEL_W-1:0] rsel_in,
  output logic [DATA_W-1:0] a_out,
  output logic [DATA_W-1:0] b_out,
  output logic [COEF_W-1:0] coef_out,
  output logic              coef_ld_out,
  output logic              fmt_out,
  output logic [RSEL_W-1:0] rsel_out
);
  import pdb_pkg::*;

  localparam int CFG_W = NUM_LANES * FIELD_W;
  localparam int W_A   = DATA_W;
  localparam int W_B   = DATA_W;
  localparam int W_C   = COEF_W + 1;
  localparam int W_F   = 1;
  localparam int W_R   = RSEL_W;
  localparam int O_A   = 0;
  localparam int O_B   = O_A + W_A;
  localparam int O_C   = O_B + W_B;
  localparam int O_F   = O_C + W_C;
  localparam int O_R   = O_F + W_F;
  localparam int TOT_W = O_R + W_R;

  function automatic int lane_w(input int idx);
    case (idx)
      LN_A:    return W_A;
      LN_B:    return W_B;
      LN_COEF: return W_C;
      LN_FMT:  return W_F;
      default: return W_R;
    endcase
  endfunction

  function automatic int lane_o(input int idx);
    case (idx)
      LN_A:    return O_A;
      LN_B:    return O_B;
      LN_COEF: return O_C;
      LN_FMT:  return O_F;
      default: return O_R;
    endcase
  endfunction

  logic             rst_int_n;
  logic [CFG_W-1:0] cfg_word;
  logic [TOT_W-1:0] lanes_in, lanes_out;

  pdb_rst_sync u_rst (
    .clk    (clk),
    .arst_n (rst_n),
    .srst_n (rst_int_n)
  );

  pdb_cfg_shreg #(.CFG_W(CFG_W)) u_cfg (
    .clk    (clk),
    .rst_n  (rst_int_n),
    .bypass (bypass),
    .strobe (cfg_strobe),
    .sdata  (cfg_bit),
    .cfg    (cfg_word)
  );

  // coefficient and its enable share one lane so they stay aligned
  assign lanes_in = {rsel_in, fmt_in, coef_ld, coef_in, b_in, a_in};

  for (genvar i = 0; i < NUM_LANES; i++) begin : g_lane
    localparam int LW = lane_w(i);
    localparam int LO = lane_o(i);
    pdb_delay_lane #(.W(LW), .SEL_W(FIELD_W)) u_lane (
      .clk   (clk),
      .rst_n (rst_int_n),
      .sel   (cfg_word[i*FIELD_W +: FIELD_W]),
      .din   (lanes_in[LO +: LW]),
      .dout  (lanes_out[LO +: LW])
    );
  end

  assign a_out       = lanes_out[O_A +: W_A];
  assign b_out       = lanes_out[O_B +: W_B];
  assign coef_out    = lanes_out[O_C +: COEF_W];
  assign coef_ld_out = lanes_out[O_C + COEF_W];
  assign fmt_out     = lanes_out[O_F];
  assign rsel_out    = lanes_out[O_R +: W_R];
endmodule

// File: rtl/pdb_chk.sv
module pdb_chk #(
  parameter int DATA_W  = 12,
  parameter int RSEL_W  = 2,
  parameter int FIELD_W = 3,
  parameter int CFG_W   = 15
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bypass,
  input logic [CFG_W-1:0]  cfg_word,
  input logic [DATA_W-1:0] a_in,
  input logic [DATA_W-1:0] a_out,
  input logic              coef_ld,
  input logic              coef_ld_out,
  input logic              fmt_in,
  input logic              fmt_out,
  input logic [RSEL_W-1:0] rsel_in,
  input logic [RSEL_W-1:0] rsel_out
);
  import pdb_pkg::*;

  logic [3:0] warm_q;
  logic       warm;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)               warm_q <= '0;
    else if (warm_q != 4'hF)  warm_q <= warm_q + 4'd1;
  end
  assign warm = (warm_q == 4'hF);

  logic [FIELD_W-1:0] f_a, f_c, f_f, f_r;
  assign f_a = cfg_word[int'(LN_A)    * FIELD_W +: FIELD_W];
  assign f_c = cfg_word[int'(LN_COEF) * FIELD_W +: FIELD_W];
  assign f_f = cfg_word[int'(LN_FMT)  * FIELD_W +: FIELD_W];
  assign f_r = cfg_word[int'(LN_RSEL) * FIELD_W +: FIELD_W];

  // R6
  bypass_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bypass |=> (cfg_word == '0));

  // R4
  shift_dir_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (warm && !bypass && (cfg_word != $past(cfg_word)))
      |-> (cfg_word[CFG_W-2:0] == $past(cfg_word[CFG_W-1:1])));

  // R3
  tap_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (f_a == '0) |-> (a_out == a_in));

  // R3
  tap_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (warm && f_a == 1 && $past(f_a) == 1) |-> (a_out == $past(a_in)));

  // R7
  ld_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (warm && f_c == 1 && $past(f_c) == 1) |-> (coef_ld_out == $past(coef_ld)));

  // R2
  lane_map_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (f_f == '0 && f_r == '0) |-> (fmt_out == fmt_in && rsel_out == rsel_in));
endmodule

bind prog_delay_bank pdb_chk #(
  .DATA_W (DATA_W),
  .RSEL_W (RSEL_W),
  .FIELD_W(FIELD_W),
  .CFG_W  (CFG_W)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .bypass     (bypass),
  .cfg_word   (cfg_word),
  .a_in       (a_in),
  .a_out      (a_out),
  .coef_ld    (coef_ld),
  .coef_ld_out(coef_ld_out),
  .fmt_in     (fmt_in),
  .fmt_out    (fmt_out),
  .rsel_in    (rsel_in),
  .rsel_out   (rsel_out)
);

// File: tb/prog_delay_bank_bench.sv
`timescale 1ns/1ps
module prog_delay_bank_bench;
  logic        clk = 1'b0;
  logic        rst_n, bypass, cfg_strobe, cfg_bit;
  logic [11:0] a_in, b_in, coef_in;
  logic        coef_ld, fmt_in;
  logic [1:0]  rsel_in;
  logic [11:0] a_out, b_out, coef_out;
  logic        coef_ld_out, fmt_out;
  logic [1:0]  rsel_out;

  always #10 clk = ~clk;

  prog_delay_bank u_prog_delay_bank (
    .clk(clk), .rst_n(rst_n), .bypass(bypass),
    .cfg_strobe(cfg_strobe), .cfg_bit(cfg_bit),
    .a_in(a_in), .b_in(b_in), .coef_in(coef_in), .coef_ld(coef_ld),
    .fmt_in(fmt_in), .rsel_in(rsel_in),
    .a_out(a_out), .b_out(b_out), .coef_out(coef_out),
    .coef_ld_out(coef_ld_out), .fmt_out(fmt_out), .rsel_out(rsel_out)
  );

  int          errors = 0;
  int          checks = 0;
  int          cyc = 0;
  bit          done = 0;
  logic [14:0] cfg_m = '0;
  logic [11:0] ha [256];
  logic [11:0] hb [256];
  logic [11:0] hc [256];
  logic        hl [256];
  logic        hf [256];
  logic [1:0]  hr [256];

  function automatic int fld(input logic [14:0] w, input int lane);
    return int'(w[lane*3 +: 3]);
  endfunction

  function automatic int slot(input int c, input int d);
    return (c - d) & 255;
  endfunction

  task automatic chk(input string tag, input string nm, input logic [11:0] got, input logic [11:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s %s got=%h exp=%h cyc=%0d", tag, nm, got, exp, cyc);
    end
  endtask

  task automatic step(input bit chk_en, input string tag);
    @(negedge clk);
    a_in    = 12'($urandom);
    b_in    = 12'($urandom);
    coef_in = 12'($urandom);
    coef_ld = 1'($urandom);
    fmt_in  = 1'($urandom);
    rsel_in = 2'($urandom);
    cyc++;
    ha[cyc & 255] = a_in; hb[cyc & 255] = b_in; hc[cyc & 255] = coef_in;
    hl[cyc & 255] = coef_ld; hf[cyc & 255] = fmt_in; hr[cyc & 255] = rsel_in;
    #1;
    if (chk_en) begin
      chk(tag, "a_out",    a_out,    ha[slot(cyc, fld(cfg_m, 0))]);
      chk(tag, "b_out",    b_out,    hb[slot(cyc, fld(cfg_m, 1))]);
      chk(tag, "coef_out", coef_out, hc[slot(cyc, fld(cfg_m, 2))]);
      chk("R7", "coef_ld_out", {11'd0, coef_ld_out}, {11'd0, hl[slot(cyc, fld(cfg_m, 2))]});
      chk(tag, "fmt_out",  {11'd0, fmt_out},  {11'd0, hf[slot(cyc, fld(cfg_m, 3))]});
      chk(tag, "rsel_out", {10'd0, rsel_out}, {10'd0, hr[slot(cyc, fld(cfg_m, 4))]});
    end
  endtask

  // one strobe pulse: rises with the bit, held high for `hi` cycles
  task automatic send_bit(input logic b, input int hi);
    step(0, "");
    cfg_strobe = 1'b1;
    cfg_bit    = b;
    for (int k = 0; k < hi; k++) step(0, "");
    cfg_strobe = 1'b0;
    for (int k = 0; k < 3; k++) step(0, "");
    if (!bypass) cfg_m = {b, cfg_m[14:1]};
  endtask

  task automatic load_word(input logic [14:0] w);
    for (int i = 0; i < 15; i++) send_bit(w[i], 3);
  endtask

  task automatic run(input int n, input string tag);
    for (int k = 0; k < n; k++) step(1, tag);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd7731));
    rst_n = 1'b0; bypass = 1'b0; cfg_strobe = 1'b0; cfg_bit = 1'b0;
    a_in = '0; b_in = '0; coef_in = '0; coef_ld = 1'b0; fmt_in = 1'b0; rsel_in = '0;
    for (int k = 0; k < 4; k++) step(0, "");
    rst_n = 1'b1;
    for (int k = 0; k < 4; k++) step(0, "");

    // R1: all zero delays after reset
    run(6, "R1");

    // R2 R4: distinct value per field, bit order fixed by the shift
    load_word({3'd5, 3'd2, 3'd7, 3'd4, 3'd1});
    run(20, "R2 R4");

    // R3 boundaries: every field at maximum, then every field at zero
    load_word(15'h7FFF);
    run(12, "R3");
    load_word(15'h0000);
    run(6, "R3");

    // R3 random words
    for (int n = 0; n < 10; n++) begin
      load_word(15'($urandom));
      run(16, "R3");
    end

    // R5: one extra rising edge shifts exactly one place
    load_word({3'd6, 3'd3, 3'd0, 3'd5, 3'd2});
    send_bit(1'b1, 3);
    run(12, "R5");
    // R5: strobe held high for a long time still gives one shift
    send_bit(1'b0, 40);
    run(12, "R5");

    // R6: bypass clears and ignores strobes
    step(0, "");
    bypass = 1'b1;
    cfg_m  = '0;
    run(6, "R6");
    send_bit(1'b1, 3);
    send_bit(1'b1, 3);
    run(6, "R6");
    bypass = 1'b0;
    run(6, "R6");
    load_word({3'd1, 3'd7, 3'd3, 3'd0, 3'd4});
    run(12, "R6");

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule